// File: doc/BRIEF.md
# PCI I/O Window Address Translator

This block sits between an internal system bus and a PCI bus master engine. It watches single-beat requests from the internal side and forwards those that land in a fixed I/O window as PCI I/O-space requests. The low address bits pass straight through. The top of the PCI address comes from a programmable base register. Three middle bits are merged one by one from the incoming address or the base register, under a mask register.

Data crosses between a big-endian internal side and a little-endian PCI side. A control bit picks whether the byte lanes are reversed. When they are reversed, the byte enables are mirrored to match. The same reversal is applied to write data going out and to read data coming back.

Requests that are bursts, that use the reserved size code, or that straddle a 4-byte unit are refused with a one-cycle error pulse. Requests outside the window are ignored. The request path has one register stage. The read-return path is combinational.

Top module: `pci_io_xlate`

## Requirements
- R1: A valid request with address from 0xFD20_0000 to 0xFE3F_FFFF inclusive produces `pci_req_o` high for exactly the cycle after it is sampled. A request outside that range produces neither `pci_req_o` nor `err_o`.
- R2: A request in the window with `req_burst_i` high is not forwarded. It raises `err_o` instead.
- R3: `req_size_i` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and 3 is reserved. An in-window request is refused with `err_o` if it uses code 3, if it is 2 bytes at an odd address, or if it is 4 bytes at an address with bits [1:0] not zero.
- R4: PCI address bits [17:0] equal the incoming address bits [17:0].
- R5: For each of PCI address bits [20:18], a mask bit of 1 takes the incoming address bit and a mask bit of 0 takes the base register bit.
- R6: PCI address bits [31:21] equal base register bits [31:21].
- R7: With swap off, `pci_be_o` has bits set for lanes off through off+n-1, where off = address[1:0] and n = the access size in bytes. With swap on, this pattern is mirrored, so lane k moves to lane 3-k.
- R8: `pci_we_o` copies `req_we_i`. `pci_wdata_o` equals `req_wdata_i` with swap off, and the same word with its four bytes reversed with swap on.
- R9: `rsp_valid_o` follows `pci_rvalid_i` in the same cycle. `rsp_rdata_o` is `pci_rdata_i`, with bytes reversed when swap is on.
- R10: Register writes use `reg_sel_i`: 0 selects the base (bits [31:18] of `reg_wdata_i`), 1 selects the mask (bits [20:18]), and 2 selects control (bit 0 = swap). Selector 3 changes nothing. All three registers reset to zero. A write takes effect for requests sampled at later edges.
- R11: `pci_req_o` and `err_o` are never high together. Each lasts one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 32 | Internal byte address |
| req_size_i | input | 2 | Access size code |
| req_burst_i | input | 1 | Request is a burst |
| req_we_i | input | 1 | Write when high, read when low |
| req_wdata_i | input | 32 | Write data, internal byte order |
| err_o | output | 1 | One-cycle refusal pulse |
| rsp_valid_o | output | 1 | Read data returned |
| rsp_rdata_o | output | 32 | Read data, internal byte order |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register selector |
| reg_wdata_i | input | 32 | Register write data |
| pci_req_o | output | 1 | Outbound PCI I/O request |
| pci_we_o | output | 1 | Outbound write flag |
| pci_addr_o | output | 32 | Outbound PCI I/O address |
| pci_be_o | output | 4 | Outbound byte enables, active high |
| pci_wdata_o | output | 32 | Outbound write data, PCI byte order |
| pci_rvalid_i | input | 1 | Read data from PCI side valid |
| pci_rdata_i | input | 32 | Read data, PCI byte order |

## Verification
Random addresses are drawn mostly inside the window, mixed with random sizes, burst flags and register settings. Mask values between all-zero and all-one show that each middle bit is selected on its own and not as a group. Directed requests probe the four addresses on either side of both window edges, and each misalignment and reserved-size case, with swap on and off. This separates a mirrored lane pattern from a shifted one, and shows that a single-byte lane moves under swap. Writes to the unused selector, followed by a request, show that no register changed.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int AW     = 32,
  parameter int MID_LO = 18,
  parameter int MID_HI = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [1:0]           sel_i,
  input  logic [AW-1:0]        wdata_i,
  output logic [AW-1:MID_LO]   base_o,
  output logic [MID_HI:MID_LO] mask_o,
  output logic                 swap_o
);
  logic [AW-1:MID_LO]   base_q;
  logic [MID_HI:MID_LO] mask_q;
  logic                 swap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
      swap_q <= 1'b0;
    end else if (we_i) begin
      unique case (reg_sel_e'(sel_i))
        SEL_BASE: base_q <= wdata_i[AW-1:MID_LO];
        SEL_MASK: mask_q <= wdata_i[MID_HI:MID_LO];
        SEL_CTRL: swap_q <= wdata_i[0];
        default:  ;
      endcase
    end
  end

  assign base_o = base_q;
  assign mask_o = mask_q;
  assign swap_o = swap_q;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[MID_LO-1:1]};

  // R10: registers hold unless written
  a_r10_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_q));
  a_r10_swap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || sel_i != SEL_CTRL) |=> $stable(swap_q));
endmodule

// File: rtl/pio_check.sv
module pio_check #(
  parameter int            AW     = 32,
  parameter int            NB     = 4,
  parameter logic [AW-1:0] WIN_LO = 32'hFD20_0000,
  parameter logic [AW-1:0] WIN_HI = 32'hFE3F_FFFF
) (
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          burst_i,
  output logic          fwd_o,
  output logic          err_o,
  output logic [NB-1:0] be_o
);
  localparam int OFF_W = $clog2(NB);

  logic hit, size_ok, align_ok;
  int   n_bytes, off;

  always_comb begin
    hit      = (addr_i >= WIN_LO) && (addr_i <= WIN_HI);
    size_ok  = (int'(size_i) <= OFF_W);
    n_bytes  = 1 << int'(size_i);
    off      = int'(addr_i[OFF_W-1:0]);
    align_ok = (off % n_bytes) == 0;
    for (int k = 0; k < NB; k++) begin
      be_o[k] = size_ok && (k >= off) && (k < off + n_bytes);
    end
  end

  assign fwd_o = valid_i && hit && !burst_i && size_ok && align_ok;
  assign err_o = valid_i && hit && (burst_i || !size_ok || !align_ok);
endmodule

// File: rtl/pio_swap.sv
module pio_swap #(
  parameter int NB = 4
) (
  input  logic            en_i,
  input  logic [8*NB-1:0] data_i,
  input  logic [NB-1:0]   be_i,
  output logic [8*NB-1:0] data_o,
  output logic [NB-1:0]   be_o
);
  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign data_o[8*k +: 8] = en_i ? data_i[8*(NB-1-k) +: 8] : data_i[8*k +: 8];
    assign be_o[k]          = en_i ? be_i[NB-1-k] : be_i[k];
  end
endmodule

// File: rtl/pci_io_xlate.sv
module pci_io_xlate #(
  parameter int            AW     = 32,
  parameter int            DW     = 32,
  parameter int            MID_LO = 18,
  parameter int            MID_HI = 20,
  parameter logic [AW-1:0] WIN_LO = 32'hFD20_0000,
  parameter logic [AW-1:0] WIN_HI = 32'hFE3F_FFFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_burst_i,
  input  logic          req_we_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          err_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic          pci_req_o,
  output logic          pci_we_o,
  output logic [AW-1:0] pci_addr_o,
  output logic [DW/8-1:0] pci_be_o,
  output logic [DW-1:0] pci_wdata_o,
  input  logic          pci_rvalid_i,
  input  logic [DW-1:0] pci_rdata_i
);
  localparam int NB = DW / 8;

  logic [AW-1:MID_LO]   base;
  logic [MID_HI:MID_LO] mask;
  logic                 swap;

  pio_regs #(.AW(AW), .MID_LO(MID_LO), .MID_HI(MID_HI)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .base_o(base), .mask_o(mask), .swap_o(swap)
  );

  logic          fwd, rej;
  logic [NB-1:0] be_nat;

  pio_check #(.AW(AW), .NB(NB), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_check (
    .valid_i(req_valid_i), .addr_i(req_addr_i), .size_i(req_size_i),
    .burst_i(req_burst_i), .fwd_o(fwd), .err_o(rej), .be_o(be_nat)
  );

  logic [DW-1:0] wdata_sw;
  logic [NB-1:0] be_sw;

  pio_swap #(.NB(NB)) u_wswap (
    .en_i(swap), .data_i(req_wdata_i), .be_i(be_nat),
    .data_o(wdata_sw), .be_o(be_sw)
  );

  logic [NB-1:0] rbe_unused;
  pio_swap #(.NB(NB)) u_rswap (
    .en_i(swap), .data_i(pci_rdata_i), .be_i('0),
    .data_o(rsp_rdata_o), .be_o(rbe_unused)
  );
  assign rsp_valid_o = pci_rvalid_i;

  logic [AW-1:0] addr_x;
  always_comb begin
    addr_x[MID_LO-1:0] = req_addr_i[MID_LO-1:0];
    for (int b = MID_LO; b <= MID_HI; b++) begin
      addr_x[b] = mask[b] ? req_addr_i[b] : base[b];
    end
    addr_x[AW-1:MID_HI+1] = base[AW-1:MID_HI+1];
  end

  logic          req_q, err_q, we_q;
  logic [AW-1:0] addr_q;
  logic [NB-1:0] be_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      err_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else begin
      req_q <= fwd;
      err_q <= rej;
      if (fwd) begin
        we_q    <= req_we_i;
        addr_q  <= addr_x;
        be_q    <= be_sw;
        wdata_q <= wdata_sw;
      end
    end
  end

  assign pci_req_o   = req_q;
  assign err_o       = err_q;
  assign pci_we_o    = we_q;
  assign pci_addr_o  = addr_q;
  assign pci_be_o    = be_q;
  assign pci_wdata_o = wdata_q;

  logic unused_rbe;
  assign unused_rbe = ^rbe_unused;

  a_r11_req_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pci_req_o && err_o));
  a_r1_req_has_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_req_o |-> $past(req_valid_i));
  a_r2_no_burst_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_req_o |-> !$past(req_burst_i));
  a_r4_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_req_o |-> pci_addr_o[MID_LO-1:0] == $past(req_addr_i[MID_LO-1:0]));
  a_r7_be_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_req_o |-> ($onehot0($countones(pci_be_o)) && pci_be_o != '0));
  a_r11_err_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_valid_i));
endmodule

// File: tb/pci_io_xlate_tb.sv
`timescale 1ns/1ps
module pci_io_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_burst = 1'b0, req_we = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        pci_rvalid = 1'b0;
  logic [31:0] pci_rdata = '0;
  logic        err, rsp_valid, pci_req, pci_we;
  logic [31:0] rsp_rdata, pci_addr, pci_wdata;
  logic [3:0]  pci_be;

  int checks = 0, failures = 0;
  logic [31:18] m_base = '0;
  logic [20:18] m_mask = '0;
  logic         m_swap = 1'b0;

  always #2 clk = ~clk;

  pci_io_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_size_i(req_size),
    .req_burst_i(req_burst), .req_we_i(req_we), .req_wdata_i(req_wdata),
    .err_o(err), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .pci_req_o(pci_req), .pci_we_o(pci_we), .pci_addr_o(pci_addr),
    .pci_be_o(pci_be), .pci_wdata_o(pci_wdata),
    .pci_rvalid_i(pci_rvalid), .pci_rdata_i(pci_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rev32(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [3:0] nat_be(input logic [31:0] a, input logic [1:0] s);
    logic [3:0] p;
    p = (s == 2'd0) ? 4'b0001 : (s == 2'd1) ? 4'b0011 : 4'b1111;
    return p << a[1:0];
  endfunction

  function automatic bit is_hit(input logic [31:0] a);
    return a >= 32'hFD20_0000 && a <= 32'hFE3F_FFFF;
  endfunction

  function automatic bit is_ok(input logic [31:0] a, input logic [1:0] s, input logic b);
    if (b || s == 2'd3) return 0;
    if (s == 2'd1 && a[0]) return 0;
    if (s == 2'd2 && a[1:0] != 2'd0) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] a);
    logic [31:0] r;
    r[17:0] = a[17:0];
    for (int b = 18; b <= 20; b++) r[b] = m_mask[b] ? a[b] : m_base[b];
    r[31:21] = m_base[31:21];
    return r;
  endfunction

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (sel == 2'd0) m_base = d[31:18];
    else if (sel == 2'd1) m_mask = d[20:18];
    else if (sel == 2'd2) m_swap = d[0];
  endtask

  task automatic do_req(input logic [31:0] a, input logic [1:0] s, input logic b,
                        input logic w, input logic [31:0] d);
    bit h, ok;
    logic [3:0] be;
    h = is_hit(a); ok = is_ok(a, s, b);
    be = m_swap ? {nat_be(a, s)[0], nat_be(a, s)[1], nat_be(a, s)[2], nat_be(a, s)[3]} : nat_be(a, s);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = s; req_burst = b; req_we = w; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    // R1 / R2 / R3 decisions
    chk(pci_req == (h && ok), "R1 R2 R3 forward", {31'd0, pci_req}, {31'd0, h && ok});
    chk(err == (h && !ok), "R2 R3 error", {31'd0, err}, {31'd0, h && !ok});
    if (h && ok) begin
      chk(pci_addr[17:0] == a[17:0], "R4 low bits", pci_addr, a);
      chk(pci_addr == exp_addr(a), "R5 R6 addr", pci_addr, exp_addr(a));
      chk(pci_be == be, "R7 be", {28'd0, pci_be}, {28'd0, be});
      chk(pci_we == w, "R8 we", {31'd0, pci_we}, {31'd0, w});
      if (w) chk(pci_wdata == (m_swap ? rev32(d) : d), "R8 wdata", pci_wdata, m_swap ? rev32(d) : d);
    end
    @(negedge clk);
    chk(!pci_req && !err, "R11 single cycle", {30'd0, pci_req, err}, 32'd0);
  endtask

  task automatic do_rd(input logic [31:0] d);
    @(negedge clk);
    pci_rvalid = 1'b1; pci_rdata = d;
    #1;
    chk(rsp_valid == 1'b1, "R9 rvalid", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_rdata == (m_swap ? rev32(d) : d), "R9 rdata", rsp_rdata, m_swap ? rev32(d) : d);
    @(negedge clk);
    pci_rvalid = 1'b0;
    #1;
    chk(rsp_valid == 1'b0, "R9 rvalid low", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(!pci_req && !err, "R10 reset outputs", {30'd0, pci_req, err}, 32'd0);
    rst_n = 1'b1;

    // R10 zero reset: upper/middle bits from zero base, no swap
    do_req(32'hFD3C_1234, 2'd2, 1'b0, 1'b1, 32'h1122_3344);
    chk(pci_addr == 32'h0000_1234, "R10 reset regs", pci_addr, 32'h0000_1234);

    // R1 window edges
    do_req(32'hFD20_0000, 2'd2, 1'b0, 1'b0, 32'h0);
    do_req(32'hFD1F_FFFC, 2'd2, 1'b0, 1'b0, 32'h0);
    do_req(32'hFE3F_FFFC, 2'd2, 1'b0, 1'b0, 32'h0);
    do_req(32'hFE40_0000, 2'd2, 1'b0, 1'b0, 32'h0);
    do_req(32'h1000_0001, 2'd3, 1'b1, 1'b0, 32'h0);

    // R2 / R3 refusals
    do_req(32'hFD80_0000, 2'd0, 1'b1, 1'b1, 32'hAA);
    do_req(32'hFD80_0001, 2'd1, 1'b0, 1'b1, 32'hAA);
    do_req(32'hFD80_0002, 2'd2, 1'b0, 1'b1, 32'hAA);
    do_req(32'hFD80_0000, 2'd3, 1'b0, 1'b1, 32'hAA);
    do_req(32'hFD80_0002, 2'd1, 1'b0, 1'b1, 32'hA1B2_C3D4);

    // R5 R6 per-bit mask, R7 R8 swap
    wr_reg(2'd0, 32'hABCD_4000 | (32'd5 << 18));
    wr_reg(2'd1, 32'd2 << 18);
    do_req(32'hFD3C_0ABC, 2'd0, 1'b0, 1'b1, 32'hDEAD_BEEF);
    wr_reg(2'd2, 32'd1);
    do_req(32'hFD3C_0ABD, 2'd0, 1'b0, 1'b1, 32'h0102_0304);
    do_req(32'hFD3C_0ABE, 2'd1, 1'b0, 1'b1, 32'h0102_0304);
    do_rd(32'h1122_3344);

    // R10 selector 3 ignored
    wr_reg(2'd3, 32'hFFFF_FFFF);
    do_req(32'hFD60_0100, 2'd2, 1'b0, 1'b1, 32'h5566_7788);
    chk(pci_addr == exp_addr(32'hFD60_0100), "R10 sel3 ignored", pci_addr, exp_addr(32'hFD60_0100));

    // random mix
    for (int i = 0; i < 500; i++) begin
      logic [31:0] a;
      if ($urandom_range(9) == 0) wr_reg(2'($urandom_range(3)), $urandom);
      a = ($urandom_range(7) == 0) ? $urandom : 32'hFD20_0000 + $urandom_range(32'h011F_FFFF);
      do_req(a, 2'($urandom_range(3)), ($urandom_range(7) == 0), 1'($urandom), $urandom);
      if ($urandom_range(5) == 0) do_rd($urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule